// File: doc/BRIEF.md
# Two-Level Selectable Nibble ALU

This block is a purely combinational arithmetic and logic unit fed by a single 8-bit input word. The word carries both operands: the low nibble is operand X and the high nibble is operand Y. A 2-bit group code picks one of three operation families (arithmetic, bitwise logic, comparison), and a 2-bit operation code then picks one of four operations inside that family. The block drives an 8-bit result and one status flag whose meaning depends on the operation: carry for addition, borrow for subtraction, the shifted-out bit for the two shifts.

Results settle in the same cycle as any change on the word or on either select; the block holds no state and needs no clock or reset. It is intended to sit behind a switch bank or a register and in front of a display or a capture register.

Top module: `alu_nibble_dual_sel`

## Requirements
- R1: Operand X is input word bits [3:0] and operand Y is bits [7:4] (word 8'h6F gives X=4'hF, Y=4'h6).
- R2: Group code 2'b01 selects logic: op 2'b00 gives X AND Y, 2'b01 gives X OR Y, 2'b10 gives X XOR Y, each zero-extended to 8 bits, with the flag 0.
- R3: Group 2'b01, op 2'b11 gives the bitwise inversion of the whole 8-bit word (8'hDB gives 8'h24), with the flag 0.
- R4: Group 2'b00, op 2'b00 gives X+Y through a ripple of full adders; the result is the 4-bit sum zero-extended and the flag is the carry out of bit 3 (8'hDB gives 8'h08, flag 1).
- R5: Group 2'b00, op 2'b01 gives X−Y in two's complement, sign-extended to 8 bits; the flag is the borrow, 1 exactly when X < Y unsigned (8'hDB gives 8'hFE, flag 1).
- R6: Group 2'b00, op 2'b10 shifts the whole word left by one with 0 shifted in; the flag is the old bit 7 (8'hDB gives 8'hB6, flag 1).
- R7: Group 2'b00, op 2'b11 shifts the whole word right by one with 0 shifted in; the flag is the old bit 0, the remainder of halving (8'hDB gives 8'h6D, flag 1).
- R8: Group 2'b10, ops 2'b00 (X==Y), 2'b01 (X>Y), 2'b10 (X<Y) compare unsigned and return 8'h01 if true, 8'h00 if false, with the flag 0.
- R9: Group 2'b10, op 2'b11 returns the larger of X and Y zero-extended to 8 bits (8'hDB gives 8'h0D), with the flag 0.
- R10: Group code 2'b11 returns 8'h00 with the flag 0 for every op code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sw_word | input | 8 | Operand word: X in [3:0], Y in [7:4] |
| grp_sel | input | 2 | Operation family code |
| op_sel | input | 2 | Operation code inside the family |
| result | output | 8 | Selected result |
| flag | output | 1 | Carry, borrow or shifted-out bit; 0 outside arithmetic |

## Verification
The assertions are immediate checks evaluated whenever the combinational logic re-evaluates, and they take for granted that every input bit is a known 0 or 1; an X or Z on the word would make arithmetic identities such as sum-plus-carry against native addition meaningless. The stimulus therefore drives only fully known values, from time zero onward, and changes inputs half a clock period before it samples, so no check looks at a partially updated set of inputs. A sweep covers all sixteen select pairs over a spread of words that includes equal operands, all-zero and all-one nibbles and both shift boundaries.

// File: rtl/alu_nibble_pkg.sv
// Shared select encodings for the nibble ALU.
// Assumes: a 2-bit family code and a 2-bit operation code.
package alu_nibble_pkg;
    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        GRP_ARITH  = 2'b00,
        GRP_LOGIC  = 2'b01,
        GRP_CMP    = 2'b10,
        GRP_UNUSED = 2'b11
    } grp_e;

    // arithmetic family
    localparam logic [SEL_W-1:0] OP_ADD = 2'b00;
    localparam logic [SEL_W-1:0] OP_SUB = 2'b01;
    localparam logic [SEL_W-1:0] OP_SHL = 2'b10;
    localparam logic [SEL_W-1:0] OP_SHR = 2'b11;
    // logic family
    localparam logic [SEL_W-1:0] OP_AND = 2'b00;
    localparam logic [SEL_W-1:0] OP_OR  = 2'b01;
    localparam logic [SEL_W-1:0] OP_XOR = 2'b10;
    localparam logic [SEL_W-1:0] OP_INV = 2'b11;
    // comparison family
    localparam logic [SEL_W-1:0] OP_EQ  = 2'b00;
    localparam logic [SEL_W-1:0] OP_GT  = 2'b01;
    localparam logic [SEL_W-1:0] OP_LT  = 2'b10;
    localparam logic [SEL_W-1:0] OP_MAX = 2'b11;
endpackage

// File: rtl/alu_nibble_arith.sv
// Arithmetic family: ripple add, ripple subtract, whole-word shifts.
// Assumes: operands are unsigned nibbles; word is the full input.
module alu_nibble_arith
    import alu_nibble_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic [2*NIB_W-1:0] word,
    input  logic [SEL_W-1:0]   op,
    output logic [2*NIB_W-1:0] res,
    output logic               flag
);
    localparam int WORD_W = 2 * NIB_W;

    // one full-adder chain; carry is majority, sum is parity
    function automatic logic [NIB_W:0] ripple(input logic [NIB_W-1:0] a,
                                              input logic [NIB_W-1:0] b,
                                              input logic             cin);
        logic [NIB_W:0]   c;
        logic [NIB_W-1:0] s;
        c[0] = cin;
        for (int i = 0; i < NIB_W; i++) begin
            s[i]   = a[i] ^ b[i] ^ c[i];
            c[i+1] = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
        end
        return {c[NIB_W], s};
    endfunction

    logic [NIB_W-1:0] opx, opy;
    logic [NIB_W:0]   add_r, sub_r;
    logic             borrow;

    // compute every arithmetic candidate and pick one by op
    always_comb begin
        opx    = word[NIB_W-1:0];
        opy    = word[WORD_W-1:NIB_W];
        add_r  = ripple(opx, opy, 1'b0);
        sub_r  = ripple(opx, ~opy, 1'b1);
        borrow = ~sub_r[NIB_W];
        unique case (op)
            OP_ADD:  begin res = {{NIB_W{1'b0}}, add_r[NIB_W-1:0]};   flag = add_r[NIB_W]; end
            OP_SUB:  begin res = {{NIB_W{borrow}}, sub_r[NIB_W-1:0]}; flag = borrow;       end
            OP_SHL:  begin res = {word[WORD_W-2:0], 1'b0};           flag = word[WORD_W-1]; end
            default: begin res = {1'b0, word[WORD_W-1:1]};           flag = word[0];        end
        endcase

        // R4
        add_carry_chk: assert ({1'b0, add_r} == ({1'b0, opx} + {1'b0, opy}))
            else $error("ripple sum disagrees with native addition");
        // R5
        sub_borrow_chk: assert (borrow == (opx < opy))
            else $error("borrow disagrees with unsigned compare");
        // R6
        shl_loss_chk: assert (op != OP_SHL || {flag, res} == ({1'b0, word} << 1))
            else $error("left shift loses or invents a bit");
        // R7
        shr_rem_chk: assert (op != OP_SHR || ({1'b0, res} * 2 + {{WORD_W{1'b0}}, flag}) == {1'b0, word})
            else $error("halving does not reconstruct the word");
    end
endmodule

// File: rtl/alu_nibble_logic.sv
// Logic family: bitwise AND/OR/XOR of the nibbles, whole-word inversion.
// Assumes: results of nibble ops are zero-extended; no flag is produced.
module alu_nibble_logic
    import alu_nibble_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic [2*NIB_W-1:0] word,
    input  logic [SEL_W-1:0]   op,
    output logic [2*NIB_W-1:0] res
);
    localparam int WORD_W = 2 * NIB_W;

    logic [NIB_W-1:0] opx, opy, v_and, v_or, v_xor;

    // form the three nibble results and the inversion, then select
    always_comb begin
        opx   = word[NIB_W-1:0];
        opy   = word[WORD_W-1:NIB_W];
        v_and = opx & opy;
        v_or  = opx | opy;
        v_xor = opx ^ opy;
        unique case (op)
            OP_AND:  res = {{NIB_W{1'b0}}, v_and};
            OP_OR:   res = {{NIB_W{1'b0}}, v_or};
            OP_XOR:  res = {{NIB_W{1'b0}}, v_xor};
            default: res = ~word;
        endcase

        // R2
        and_in_or_chk: assert ((v_and & ~v_or) == '0 && v_xor == (v_or & ~v_and))
            else $error("AND/OR/XOR results are mutually inconsistent");
        // R3
        inv_disjoint_chk: assert (op != OP_INV || ((res & word) == '0 && (res | word) == '1))
            else $error("inversion is not the complement of the word");
    end
endmodule

// File: rtl/alu_nibble_cmp.sv
// Comparison family: unsigned equal, greater, less and maximum.
// Assumes: predicates return 1 or 0 in the low bit; max is zero-extended.
module alu_nibble_cmp
    import alu_nibble_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic [2*NIB_W-1:0] word,
    input  logic [SEL_W-1:0]   op,
    output logic [2*NIB_W-1:0] res
);
    localparam int WORD_W = 2 * NIB_W;

    logic [NIB_W-1:0] opx, opy, big;
    logic             is_eq, is_gt, is_lt;

    // evaluate the three predicates and the maximum, then select
    always_comb begin
        opx   = word[NIB_W-1:0];
        opy   = word[WORD_W-1:NIB_W];
        is_eq = (opx == opy);
        is_gt = (opx > opy);
        is_lt = (opx < opy);
        big   = is_lt ? opy : opx;
        unique case (op)
            OP_EQ:   res = {{(WORD_W-1){1'b0}}, is_eq};
            OP_GT:   res = {{(WORD_W-1){1'b0}}, is_gt};
            OP_LT:   res = {{(WORD_W-1){1'b0}}, is_lt};
            default: res = {{NIB_W{1'b0}}, big};
        endcase

        // R8
        one_pred_chk: assert ($countones({is_eq, is_gt, is_lt}) == 1)
            else $error("comparison predicates are not exclusive");
        // R9
        max_bound_chk: assert (big >= opx && big >= opy && (big == opx || big == opy))
            else $error("maximum is not the larger operand");
    end
endmodule

// File: rtl/alu_nibble_dual_sel.sv
// Top: splits the word into two nibble operands, runs all three
// families in parallel and selects one by family code.
// Assumes: purely combinational; the unused family code yields zero.
module alu_nibble_dual_sel
    import alu_nibble_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic [2*NIB_W-1:0] sw_word,
    input  logic [SEL_W-1:0]   grp_sel,
    input  logic [SEL_W-1:0]   op_sel,
    output logic [2*NIB_W-1:0] result,
    output logic               flag
);
    localparam int WORD_W = 2 * NIB_W;

    logic [WORD_W-1:0] ar_res, lg_res, cp_res;
    logic              ar_flag;

    alu_nibble_arith #(.NIB_W(NIB_W)) u_arith (
        .word(sw_word), .op(op_sel), .res(ar_res), .flag(ar_flag)
    );
    alu_nibble_logic #(.NIB_W(NIB_W)) u_logic (
        .word(sw_word), .op(op_sel), .res(lg_res)
    );
    alu_nibble_cmp #(.NIB_W(NIB_W)) u_cmp (
        .word(sw_word), .op(op_sel), .res(cp_res)
    );

    // outer family select; flag only passes for arithmetic
    always_comb begin
        unique case (grp_e'(grp_sel))
            GRP_ARITH: begin result = ar_res; flag = ar_flag; end
            GRP_LOGIC: begin result = lg_res; flag = 1'b0;    end
            GRP_CMP:   begin result = cp_res; flag = 1'b0;    end
            default:   begin result = '0;     flag = 1'b0;    end
        endcase
    end
endmodule

// File: tb/test_alu_nibble_dual_sel.sv
module test_alu_nibble_dual_sel;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 26;

    logic       clk = 1'b0;
    logic [7:0] sw_word = 8'h00;
    logic [1:0] grp_sel = 2'b11;
    logic [1:0] op_sel  = 2'b00;
    logic [7:0] result;
    logic       flag;
    int         n_cmp = 0, n_bad = 0;
    int         cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_nibble_dual_sel i_alu_nibble_dual_sel (
        .sw_word(sw_word), .grp_sel(grp_sel), .op_sel(op_sel),
        .result(result), .flag(flag)
    );

    // {word, grp, op, expected result, expected flag}
    localparam logic [20:0] VEC [NVEC] = '{
        {8'h6F, 2'd0, 2'd0, 8'h05, 1'b1},  // R1 R4
        {8'hDB, 2'd0, 2'd0, 8'h08, 1'b1},  // R4
        {8'h21, 2'd0, 2'd0, 8'h03, 1'b0},  // R1 R4
        {8'hDB, 2'd0, 2'd1, 8'hFE, 1'b1},  // R5
        {8'h2B, 2'd0, 2'd1, 8'h09, 1'b0},  // R5
        {8'h55, 2'd0, 2'd1, 8'h00, 1'b0},  // R5
        {8'hF0, 2'd0, 2'd1, 8'hF1, 1'b1},  // R5
        {8'hDB, 2'd0, 2'd2, 8'hB6, 1'b1},  // R6
        {8'h41, 2'd0, 2'd2, 8'h82, 1'b0},  // R6
        {8'hDB, 2'd0, 2'd3, 8'h6D, 1'b1},  // R7
        {8'h80, 2'd0, 2'd3, 8'h40, 1'b0},  // R7
        {8'hDB, 2'd1, 2'd0, 8'h09, 1'b0},  // R2
        {8'hDB, 2'd1, 2'd1, 8'h0F, 1'b0},  // R2
        {8'hDB, 2'd1, 2'd2, 8'h06, 1'b0},  // R2
        {8'hDB, 2'd1, 2'd3, 8'h24, 1'b0},  // R3
        {8'h00, 2'd1, 2'd3, 8'hFF, 1'b0},  // R3
        {8'hDB, 2'd2, 2'd0, 8'h00, 1'b0},  // R8
        {8'hDB, 2'd2, 2'd1, 8'h00, 1'b0},  // R8
        {8'hDB, 2'd2, 2'd2, 8'h01, 1'b0},  // R8
        {8'h77, 2'd2, 2'd0, 8'h01, 1'b0},  // R8
        {8'h3A, 2'd2, 2'd1, 8'h01, 1'b0},  // R8
        {8'hDB, 2'd2, 2'd3, 8'h0D, 1'b0},  // R9
        {8'h3A, 2'd2, 2'd3, 8'h0A, 1'b0},  // R9
        {8'hFF, 2'd3, 2'd0, 8'h00, 1'b0},  // R10
        {8'hFF, 2'd3, 2'd2, 8'h00, 1'b0},  // R10
        {8'h5A, 2'd3, 2'd3, 8'h00, 1'b0}   // R10
    };

    // reference model written from the requirements
    function automatic logic [8:0] model(input logic [7:0] w, input logic [1:0] g,
                                          input logic [1:0] o);
        int x, y, d;
        x = int'(w[3:0]);
        y = int'(w[7:4]);
        case (g)
            2'd0: case (o)
                2'd0: return {(x + y) > 15, 4'h0, 4'((x + y) % 16)};
                2'd1: begin d = x - y; return {x < y, 8'(d)}; end
                2'd2: return {w[7], w[6:0], 1'b0};
                default: return {w[0], 1'b0, w[7:1]};
            endcase
            2'd1: case (o)
                2'd0: return {1'b0, 4'h0, w[3:0] & w[7:4]};
                2'd1: return {1'b0, 4'h0, w[3:0] | w[7:4]};
                2'd2: return {1'b0, 4'h0, w[3:0] ^ w[7:4]};
                default: return {1'b0, ~w};
            endcase
            2'd2: case (o)
                2'd0: return {1'b0, 7'h0, x == y};
                2'd1: return {1'b0, 7'h0, x > y};
                2'd2: return {1'b0, 7'h0, x < y};
                default: return {1'b0, 8'(x > y ? x : y)};
            endcase
            default: return 9'h000;
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] er, input logic ef);
        n_cmp++;
        if (result !== er || flag !== ef) begin
            n_bad++;
            $display("FAIL %s word=%h grp=%0d op=%0d: got %h/%b expected %h/%b",
                     tag, sw_word, grp_sel, op_sel, result, flag, er, ef);
        end
    endtask

    task automatic apply(input logic [7:0] w, input logic [1:0] g, input logic [1:0] o);
        sw_word = w; grp_sel = g; op_sel = o;
        #(CLK_PERIOD/2);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // idle state: unused family must read zero (R10)
        #(CLK_PERIOD/2);
        check("R10 idle", 8'h00, 1'b0);

        // table of worked examples
        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][20:13], VEC[i][12:11], VEC[i][10:9]);
            check("table R1-vector", VEC[i][8:1], VEC[i][0]);
        end

        // sweep of all select pairs against the model (R2..R10)
        for (int k = 0; k < 64; k++) begin
            logic [7:0] w;
            w = 8'((k * 37 + (k >> 2) * 5) % 256);
            if (k == 60) w = 8'h00;
            if (k == 61) w = 8'hFF;
            if (k == 62) w = 8'h99;
            if (k == 63) w = 8'h0F;
            for (int s = 0; s < 16; s++) begin
                logic [8:0] m;
                m = model(w, 2'(s >> 2), 2'(s % 4));
                apply(w, 2'(s >> 2), 2'(s % 4));
                check("sweep R2 R4 R5 R6 R7 R8 R9 R10", m[7:0], m[8]);
            end
        end

        // corner: all-ones add and zero minus zero
        apply(8'hFF, 2'd0, 2'd0);
        check("R4 max carry", 8'h0E, 1'b1);
        apply(8'h00, 2'd0, 2'd1);
        check("R5 zero diff", 8'h00, 1'b0);
        // corner: flag from shifts of single edge bits
        apply(8'h01, 2'd0, 2'd3);
        check("R7 lone lsb", 8'h00, 1'b1);
        apply(8'h80, 2'd0, 2'd2);
        check("R6 lone msb", 8'h00, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule